// File: doc/BRIEF.md
# Adaptive Synchronous-Rectifier Gate Sequencer

This block drives the two gates of a secondary-side synchronous rectifier from the switching events of the lagging (C/D) leg of a phase-shifted full bridge. Each time that leg flips, the rectifier gate on the side that is now conducting turns on. The gate that stops conducting stays on for an overlap of `td3_cycles` clock cycles before it turns off, so both rectifiers conduct through the freewheeling interval. The gate pair fits both centre-tap and current-doubler full-wave rectifiers.

The overlap is chosen again on every flip. It falls to zero in three cases: the loop control word shows light load, the flip was caused by the cycle-by-cycle current limit rather than by the phase comparator, or soft-start has not yet finished since the block was enabled. Light load is found with two programmable 8-bit thresholds, which give hysteresis. All event and control pins are plain levels or single-cycle pulses sampled on the clock. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sr_gate_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any cycle in which `enable` is sampled low, `gate_e` and `gate_f` are both 0.
- R2: In the first cycle sampled with `enable` high after it was low, both gates are driven 0. Both stay 0 until the first accepted `leg_flip`.
- R3: A `leg_flip` pulse sampled while running has `leg_c` giving the new leg state: 1 means C is on, 0 means D is on. After that edge the incoming gate (`gate_f` for `leg_c`=1, `gate_e` for `leg_c`=0) is 1. This fixed one-cycle latency is the TD4 offset.
- R4: When no zero-gap condition holds, the outgoing gate stays at its prior value for exactly `td3_cycles` clock edges after the flip, then goes to 0. With `td3_cycles`=0, both gates change at the flip edge.
- R5: A light-load flag is set when `ctrl_word` < `ll_enter_th` and cleared when `ctrl_word` > `ll_exit_th`; otherwise it holds. It is registered, so it affects flips from the next cycle on. A flip taken while the flag is set uses a zero overlap. The flag is cleared while `enable` is low.
- R6: A flip with `flip_by_ocp`=1 turns the outgoing gate off at the same edge as the incoming gate turns on. The next flip with `flip_by_ocp`=0 uses `td3_cycles` again.
- R7: Until `ss_done` has been sampled high at least once since `enable` rose, every flip uses a zero overlap. The flag is sticky until `enable` falls. It is registered, so a flip in the same cycle as the first `ss_done` still uses zero.
- R8: A flip that arrives while an earlier overlap is still counting cancels that countdown. The timing restarts from the new flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces both gates off |
| leg_flip | input | 1 | One-cycle pulse: the C/D leg switched |
| leg_c | input | 1 | New leg state with the flip: 1 = C on, 0 = D on |
| flip_by_ocp | input | 1 | Flip was caused by the current limit (1) or by the phase comparator (0) |
| ctrl_word | input | CW_W | Loop control word (error-amplifier level) |
| ll_enter_th | input | CW_W | Light load entered below this code |
| ll_exit_th | input | CW_W | Light load left above this code |
| ss_done | input | 1 | Soft-start reached its completion level |
| td3_cycles | input | TD_W | Programmed overlap in clock cycles |
| gate_e | output | 1 | Rectifier gate paired with the D side |
| gate_f | output | 1 | Rectifier gate paired with the C side |

## Verification
The bench builds the block with its defaults: `CW_W`=8 and `TD_W`=6. During random traffic it keeps `td3_cycles` below 8, and flips arrive on average about every eight cycles. Many flips therefore land inside a running overlap, which exercises the cancellation in R8. Control words are drawn around the two thresholds, so the light-load flag toggles often and rests at length in the hysteresis band between them. Current-limit flips and late soft-start completion are mixed into the same run, so all three zero-gap causes meet each other and the normal programmed overlap.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  // Which rectifier gate a leg state selects.
  typedef enum logic {
    SIDE_E = 1'b0,
    SIDE_F = 1'b1
  } sr_side_e;

  typedef struct packed {
    logic e;
    logic f;
  } sr_gates_t;

  function automatic sr_side_e side_of(input logic c_on);
    return c_on ? SIDE_F : SIDE_E;
  endfunction
endpackage

// File: rtl/sr_load_detect.sv
module sr_load_detect #(
  parameter int CW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [CW_W-1:0] enter_th,
  input  logic [CW_W-1:0] exit_th,
  output logic            light
);
  logic light_q;
  logic light_d;

  // Hysteresis: enter below one code, leave above another.
  always_comb begin
    light_d = light_q;
    if (!light_q && (ctrl_word < enter_th)) light_d = 1'b1;
    if (light_q && (ctrl_word > exit_th))   light_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   light_q <= 1'b0;
    else if (clr) light_q <= 1'b0;
    else          light_q <= light_d;
  end

  assign light = light_q;
endmodule

// File: rtl/sr_start_guard.sv
module sr_start_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ss_done,
  output logic ss_seen
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (clr)     seen_q <= 1'b0;
    else if (ss_done) seen_q <= 1'b1;
  end

  assign ss_seen = seen_q;
endmodule

// File: rtl/sr_gap_timer.sv
module sr_gap_timer #(
  parameter int TD_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [TD_W-1:0] load_val,
  output logic            expire
);
  localparam logic [TD_W-1:0] ONE = TD_W'(1);

  logic [TD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - ONE;
  end

  assign expire = (cnt_q == ONE);
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_gate_pkg::*;
#(
  parameter int CW_W = 8,
  parameter int TD_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            leg_flip,
  input  logic            leg_c,
  input  logic            flip_by_ocp,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [CW_W-1:0] ll_enter_th,
  input  logic [CW_W-1:0] ll_exit_th,
  input  logic            ss_done,
  input  logic [TD_W-1:0] td3_cycles,
  output logic            gate_e,
  output logic            gate_f
);
  localparam logic [TD_W-1:0] NO_GAP = '0;

  logic      en_q;
  logic      running;
  logic      light;
  logic      ss_seen;
  logic      zero_gap;
  logic      expire;
  logic      take_flip;
  logic [TD_W-1:0] gap;
  sr_side_e  out_side_q, out_side_d;
  sr_side_e  in_side;
  sr_gates_t gates_q, gates_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  assign running   = enable & en_q;
  assign take_flip = running & leg_flip;

  sr_load_detect #(.CW_W(CW_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!enable),
    .ctrl_word (ctrl_word),
    .enter_th  (ll_enter_th),
    .exit_th   (ll_exit_th),
    .light     (light)
  );

  sr_start_guard u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!enable),
    .ss_done (ss_done),
    .ss_seen (ss_seen)
  );

  // Overlap is chosen per flip from load, limit and start-up state.
  assign zero_gap = light | flip_by_ocp | !ss_seen;
  assign gap      = zero_gap ? NO_GAP : td3_cycles;

  sr_gap_timer #(.TD_W(TD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!running),
    .load     (take_flip),
    .load_val (gap),
    .expire   (expire)
  );

  assign in_side = side_of(leg_c);

  always_comb begin
    gates_d    = gates_q;
    out_side_d = out_side_q;
    if (expire) begin
      if (out_side_q == SIDE_F) gates_d.f = 1'b0;
      else                      gates_d.e = 1'b0;
    end
    if (take_flip) begin
      out_side_d = (in_side == SIDE_F) ? SIDE_E : SIDE_F;
      if (in_side == SIDE_F) begin
        gates_d.f = 1'b1;
        if (gap == NO_GAP) gates_d.e = 1'b0;
      end else begin
        gates_d.e = 1'b1;
        if (gap == NO_GAP) gates_d.f = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_q    <= '0;
      out_side_q <= SIDE_E;
    end else if (!running) begin
      gates_q    <= '0;
      out_side_q <= SIDE_E;
    end else begin
      gates_q    <= gates_d;
      out_side_q <= out_side_d;
    end
  end

  assign gate_e = gates_q.e;
  assign gate_f = gates_q.f;
endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic leg_flip,
  input logic leg_c,
  input logic flip_by_ocp,
  input logic gate_e,
  input logic gate_f
);
  logic en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= enable;
  end

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gate_e && !gate_f));

  p_first_cycle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_prev) |=> (!gate_e && !gate_f));

  p_incoming_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_prev && leg_flip) |=> ($past(leg_c) ? gate_f : gate_e));

  p_ocp_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_prev && leg_flip && flip_by_ocp) |=>
      ($past(leg_c) ? !gate_e : !gate_f));
endmodule

bind sr_gate_seq sr_gate_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .leg_flip    (leg_flip),
  .leg_c       (leg_c),
  .flip_by_ocp (flip_by_ocp),
  .gate_e      (gate_e),
  .gate_f      (gate_f)
);

// File: tb/sr_gate_seq_tb.sv
`timescale 1ns/1ps
module sr_gate_seq_tb_top;
  localparam int CW_W = 8;
  localparam int TD_W = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable = 1'b0;
  logic            leg_flip = 1'b0;
  logic            leg_c = 1'b0;
  logic            flip_by_ocp = 1'b0;
  logic [CW_W-1:0] ctrl_word = 8'd200;
  logic [CW_W-1:0] ll_enter_th = 8'd100;
  logic [CW_W-1:0] ll_exit_th = 8'd120;
  logic            ss_done = 1'b0;
  logic [TD_W-1:0] td3_cycles = 6'd3;
  logic            gate_e, gate_f;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state built from the requirements.
  bit m_e, m_f, m_out_f, m_ll, m_ss, m_en;
  int m_cnt;

  always #4 clk = ~clk;

  sr_gate_seq #(.CW_W(CW_W), .TD_W(TD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .leg_flip(leg_flip),
    .leg_c(leg_c), .flip_by_ocp(flip_by_ocp), .ctrl_word(ctrl_word),
    .ll_enter_th(ll_enter_th), .ll_exit_th(ll_exit_th), .ss_done(ss_done),
    .td3_cycles(td3_cycles), .gate_e(gate_e), .gate_f(gate_f)
  );

  function automatic int pick_gap(bit ll, bit ocp, bit ss, int td);
    return (ll || ocp || !ss) ? 0 : td;
  endfunction

  task automatic m_update();
    int g;
    if (!rst_n || !enable) begin
      m_e = 0; m_f = 0; m_out_f = 0; m_cnt = 0; m_ll = 0; m_ss = 0;
      m_en = rst_n ? enable : 1'b0;
      return;
    end
    g = pick_gap(m_ll, flip_by_ocp, m_ss, int'(td3_cycles));
    if (!m_en) begin
      m_en = 1; m_e = 0; m_f = 0; m_cnt = 0; m_out_f = 0;
    end else begin
      if (m_cnt != 0) begin
        if (m_cnt == 1) begin
          if (m_out_f) m_f = 0; else m_e = 0;
        end
        m_cnt = m_cnt - 1;
      end
      if (leg_flip) begin
        if (leg_c) begin m_f = 1; if (g == 0) m_e = 0; m_out_f = 0; end
        else       begin m_e = 1; if (g == 0) m_f = 0; m_out_f = 1; end
        m_cnt = g;
      end
    end
    if (!m_ll && ctrl_word < ll_enter_th) m_ll = 1;
    else if (m_ll && ctrl_word > ll_exit_th) m_ll = 0;
    if (ss_done) m_ss = 1;
  endtask

  task automatic step();
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic chk(string tag);
    n_checks++;
    if (gate_e !== m_e || gate_f !== m_f) begin
      n_fail++;
      $display("FAIL %s: gate_e/gate_f actual %b%b expected %b%b at %0t",
               tag, gate_e, gate_f, m_e, m_f, $time);
    end
  endtask

  task automatic flip(bit c, bit ocp, string tag);
    leg_flip = 1; leg_c = c; flip_by_ocp = ocp;
    step();
    leg_flip = 0; flip_by_ocp = 0;
    chk(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) begin step(); chk(tag); end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_update();
    @(negedge clk); @(negedge clk);
    chk("R1 reset");
    rst_n = 1;
    step(); chk("R1 after reset");
    // Flips while disabled are ignored.
    flip(1, 0, "R1 disabled");
    flip(0, 0, "R1 disabled");
    // Enable: first cycle and idle both low.
    enable = 1;
    step(); chk("R2 first cycle");
    ss_done = 1; step(); chk("R2 idle"); ss_done = 0;
    idle(2, "R2 idle");
    // Normal overlap of 3.
    flip(1, 0, "R3 incoming F");
    idle(2, "R3");
    flip(0, 0, "R3 incoming E");
    idle(4, "R4 overlap");
    td3_cycles = 0;
    flip(1, 0, "R4 zero program");
    idle(1, "R4");
    td3_cycles = 3;
    // Current-limit flip, then comparator flip.
    flip(0, 1, "R6 ocp flip");
    idle(3, "R6");
    flip(1, 0, "R6 restored");
    idle(4, "R6 restored");
    // Light load with hysteresis.
    ctrl_word = 90; step(); chk("R5 enter");
    flip(0, 0, "R5 light zero gap");
    idle(2, "R5");
    ctrl_word = 110; step(); chk("R5 band");
    flip(1, 0, "R5 band holds light");
    idle(2, "R5");
    ctrl_word = 130; step(); chk("R5 leave");
    flip(0, 0, "R5 overlap back");
    idle(4, "R5");
    // Flip cuts a running countdown.
    td3_cycles = 5;
    flip(1, 0, "R8 start");
    idle(2, "R8");
    flip(0, 0, "R8 restart");
    idle(6, "R8 countdown");
    // Soft-start not complete.
    enable = 0; step(); chk("R1 disable");
    enable = 1; step(); chk("R2 re-enable");
    flip(1, 0, "R7 no ss");
    idle(2, "R7");
    ss_done = 1;
    flip(0, 0, "R7 same cycle ss");
    ss_done = 0;
    idle(2, "R7");
    flip(1, 0, "R7 ss sticky");
    idle(6, "R7");
    // Random traffic.
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      leg_flip    = ($urandom % 8) == 0;
      leg_c       = $urandom % 2;
      flip_by_ocp = ($urandom % 4) == 0;
      if ($urandom % 16 == 0) ctrl_word = 8'(80 + $urandom % 60);
      if ($urandom % 64 == 0) td3_cycles = 6'($urandom % 8);
      ss_done     = ($urandom % 32) == 0;
      if ($urandom % 500 == 0) enable = 0;
      else if (!enable) enable = 1;
      step();
      chk("R3/R4/R5/R6/R7/R8 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule